// File: doc/BRIEF.md
# In-SRAM Bitline Compute Array

This block models a row-organised SRAM that computes on its own contents. Each row holds one word and each column one bit position. A plain access opens one row: a write stores a word, and a read returns a row one cycle later. A compute access opens two source rows together. The sense stage then yields, for every column, the conjunction of the two rows and the complement of their disjunction. A thin layer of peripheral logic after the sense stage turns those two signals into the remaining bitwise functions. Connections between neighbouring columns provide a ripple-carry add and single-column shifts. The result is written back into any destination row in the same cycle, where later operations can use it as an operand.

There is no multiplier. A small sequencer forms the product from one conditional add and one shift per multiplier bit. It works through the array itself and keeps its partial state in the two highest rows. Commands arrive on a valid/ready handshake that carries an opcode, two source rows, a destination row and write data. The sequencer holds off new commands while it runs.

Top module: `cim_array_top`

## Requirements
- R1: After reset every row reads as zero, cmd_ready_o is high, and rd_valid_o and mul_done_o are low.
- R2: Opcode 1 stores cmd_wdata_i into row cmd_rd_i. Opcode 0 returns row cmd_ra_i on rd_data_o, with rd_valid_o high for exactly the one cycle after acceptance.
- R3: Opcode 2 writes the bitwise AND of rows cmd_ra_i and cmd_rb_i to row cmd_rd_i. Opcode 3 writes their bitwise NOR.
- R4: Opcodes 4, 5, 6 and 7 write OR, NAND, XOR and XNOR of the two source rows to the destination row.
- R5: Opcode 8 writes the sum of the two source rows modulo 2^WIDTH to the destination. The carry ripples across every column, so all-ones plus one gives zero.
- R6: Opcode 9 shifts row cmd_ra_i one column toward the MSB and opcode 10 shifts it one column toward the LSB. Both fill with zero, and cmd_rb_i has no effect on them.
- R7: Opcode 11 writes the low WIDTH bits of the product of the two source rows to the destination. Rows ROWS-1 and ROWS-2 serve as scratch and hold the product and zero afterwards. Sources and destination may be any rows, including the scratch rows.
- R8: For opcode 11, mul_done_o pulses for one cycle exactly 2*WIDTH+4 clock cycles after acceptance, whatever the operand values. cmd_ready_o is low from the cycle after acceptance until the pulse.
- R9: A command presented while cmd_ready_o is low is not taken. Opcodes 12 to 15 change no row.
- R10: The destination row may equal a source row, and the result then replaces that operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_op_i | input | 4 | Opcode |
| cmd_ra_i | input | $clog2(ROWS) | Source row A, or the row to read |
| cmd_rb_i | input | $clog2(ROWS) | Source row B |
| cmd_rd_i | input | $clog2(ROWS) | Destination row |
| cmd_wdata_i | input | WIDTH | Write data for opcode 1 |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | WIDTH | Read data |
| mul_done_o | output | 1 | Multiply finished pulse |

## Verification
The hardest case to reach from the ports is a command arriving in the middle of a multiply, while the sequencer owns the array. The multiply test drives a write with cmd_valid_i held across a clock edge inside that window. It then reads the targeted row after completion to show the write was dropped. The same test places the operands in the scratch rows. This shows that the multiplier is captured before those rows are overwritten, and the exact done latency is counted edge by edge.

// File: rtl/cim_pkg.sv
package cim_pkg;
  typedef enum logic [3:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_AND   = 4'd2,
    OP_NOR   = 4'd3,
    OP_OR    = 4'd4,
    OP_NAND  = 4'd5,
    OP_XOR   = 4'd6,
    OP_XNOR  = 4'd7,
    OP_ADD   = 4'd8,
    OP_SHL   = 4'd9,
    OP_SHR   = 4'd10,
    OP_MUL   = 4'd11
  } cim_op_e;
endpackage

// File: rtl/cim_bit_array.sv
module cim_bit_array #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    row_a_i,
  input  logic [AW-1:0]    row_b_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [WIDTH-1:0] wd_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] nor_o
);
  logic [WIDTH-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  // dual-row activation: sense amps see both wordlines on the shared bitlines
  assign and_o = mem_q[row_a_i] & mem_q[row_b_i];
  assign nor_o = ~(mem_q[row_a_i] | mem_q[row_b_i]);
endmodule

// File: rtl/cim_periph.sv
module cim_periph
  import cim_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  cim_op_e          op_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] nor_i,
  output logic [WIDTH-1:0] res_o
);
  logic [WIDTH-1:0] or_w, nand_w, xnor_w, xor_w, sum_w, shl_w, shr_w;
  logic [WIDTH:0]   carry_w;

  assign or_w   = ~nor_i;
  assign nand_w = ~and_i;
  assign xnor_w = and_i | nor_i;
  assign xor_w  = ~xnor_w;

  assign carry_w[0] = 1'b0;
  for (genvar g = 0; g < WIDTH; g++) begin : g_col
    assign sum_w[g]       = xor_w[g] ^ carry_w[g];
    assign carry_w[g+1]   = and_i[g] | (xor_w[g] & carry_w[g]);
  end

  // single-operand ops activate the same row twice, so OR carries the operand
  assign shl_w = {or_w[WIDTH-2:0], 1'b0};
  assign shr_w = {1'b0, or_w[WIDTH-1:1]};

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = and_i;
      OP_NOR:  res_o = nor_i;
      OP_NAND: res_o = nand_w;
      OP_XOR:  res_o = xor_w;
      OP_XNOR: res_o = xnor_w;
      OP_ADD:  res_o = sum_w;
      OP_SHL:  res_o = shl_w;
      OP_SHR:  res_o = shr_w;
      default: res_o = or_w;
    endcase
  end

  // a+b = (a^b) + 2(a&b); independent of the ripple chain
  always_comb begin
    if (op_i == OP_ADD) begin
      p_add_identity_r5: assert (sum_w == WIDTH'(xor_w + (and_i << 1)));
    end
  end
endmodule

// File: rtl/cim_mul_seq.sv
module cim_mul_seq
  import cim_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    src_a_i,
  input  logic [AW-1:0]    src_b_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [WIDTH-1:0] res_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    row_a_o,
  output logic [AW-1:0]    row_b_o,
  output cim_op_e          op_o,
  output logic             we_o,
  output logic [AW-1:0]    wa_o
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [AW-1:0] ACC_ROW = AW'(ROWS - 1);
  localparam logic [AW-1:0] MCD_ROW = AW'(ROWS - 2);
  localparam logic [CW-1:0] LAST    = CW'(WIDTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_LDB, S_LDA, S_CLR, S_ADD, S_SHF, S_CPY} seq_e;

  seq_e             state_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] mplier_q;
  logic [AW-1:0]    a_q, b_q, d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      mplier_q <= '0;
      a_q      <= '0;
      b_q      <= '0;
      d_q      <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          a_q     <= src_a_i;
          b_q     <= src_b_i;
          d_q     <= dst_i;
          cnt_q   <= '0;
          state_q <= S_LDB;
        end
        S_LDB: begin
          mplier_q <= res_i;  // multiplier captured before scratch rows are touched
          state_q  <= S_LDA;
        end
        S_LDA: state_q <= S_CLR;
        S_CLR: state_q <= S_ADD;
        S_ADD: begin
          mplier_q <= mplier_q >> 1;
          state_q  <= S_SHF;
        end
        S_SHF: begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= (cnt_q == LAST) ? S_CPY : S_ADD;
        end
        S_CPY: begin
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    row_a_o = ACC_ROW;
    row_b_o = ACC_ROW;
    op_o    = OP_OR;
    we_o    = 1'b0;
    wa_o    = ACC_ROW;
    unique case (state_q)
      S_LDB: begin row_a_o = b_q; row_b_o = b_q; end
      S_LDA: begin row_a_o = a_q; row_b_o = a_q; we_o = 1'b1; wa_o = MCD_ROW; end
      S_CLR: begin row_a_o = a_q; row_b_o = a_q; op_o = OP_XOR; we_o = 1'b1; end
      S_ADD: begin row_b_o = MCD_ROW; op_o = OP_ADD; we_o = mplier_q[0]; end
      S_SHF: begin
        row_a_o = MCD_ROW; row_b_o = MCD_ROW; op_o = OP_SHL; we_o = 1'b1; wa_o = MCD_ROW;
      end
      S_CPY: begin we_o = 1'b1; wa_o = d_q; end
      default: ;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);

  p_done_after_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == S_CPY));
  p_step_pairs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADD) |=> (state_q == S_SHF));
endmodule

// File: rtl/cim_array_top.sv
module cim_array_top
  import cim_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [3:0]       cmd_op_i,
  input  logic [AW-1:0]    cmd_ra_i,
  input  logic [AW-1:0]    cmd_rb_i,
  input  logic [AW-1:0]    cmd_rd_i,
  input  logic [WIDTH-1:0] cmd_wdata_i,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             mul_done_o
);
  cim_op_e          cmd_op;
  logic             accept, single_row, writes_back, mul_start;
  logic             seq_busy, seq_we;
  logic [AW-1:0]    seq_ra, seq_rb, seq_wa;
  cim_op_e          seq_op;
  logic [AW-1:0]    arr_ra, arr_rb, arr_wa;
  logic             arr_we;
  logic [WIDTH-1:0] arr_wd, and_w, nor_w, res_w;
  cim_op_e          arr_op;

  assign cmd_op      = cim_op_e'(cmd_op_i);
  assign cmd_ready_o = ~seq_busy;
  assign accept      = cmd_valid_i & cmd_ready_o;
  assign single_row  = (cmd_op == OP_READ) || (cmd_op == OP_SHL) || (cmd_op == OP_SHR);
  assign writes_back = (cmd_op_i >= 4'd1) && (cmd_op_i <= 4'd10);
  assign mul_start   = accept && (cmd_op == OP_MUL);

  always_comb begin
    if (seq_busy) begin
      arr_ra = seq_ra;
      arr_rb = seq_rb;
      arr_op = seq_op;
      arr_we = seq_we;
      arr_wa = seq_wa;
      arr_wd = res_w;
    end else begin
      arr_ra = cmd_ra_i;
      arr_rb = single_row ? cmd_ra_i : cmd_rb_i;
      arr_op = cmd_op;
      arr_we = accept && writes_back;
      arr_wa = cmd_rd_i;
      arr_wd = (cmd_op == OP_WRITE) ? cmd_wdata_i : res_w;
    end
  end

  cim_bit_array #(.ROWS(ROWS), .WIDTH(WIDTH), .AW(AW)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .row_a_i (arr_ra),
    .row_b_i (arr_rb),
    .we_i    (arr_we),
    .wa_i    (arr_wa),
    .wd_i    (arr_wd),
    .and_o   (and_w),
    .nor_o   (nor_w)
  );

  cim_periph #(.WIDTH(WIDTH)) i_periph (
    .op_i  (arr_op),
    .and_i (and_w),
    .nor_i (nor_w),
    .res_o (res_w)
  );

  cim_mul_seq #(.ROWS(ROWS), .WIDTH(WIDTH), .AW(AW)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (mul_start),
    .src_a_i  (cmd_ra_i),
    .src_b_i  (cmd_rb_i),
    .dst_i    (cmd_rd_i),
    .res_i    (res_w),
    .busy_o   (seq_busy),
    .done_o   (mul_done_o),
    .row_a_o  (seq_ra),
    .row_b_o  (seq_rb),
    .op_o     (seq_op),
    .we_o     (seq_we),
    .wa_o     (seq_wa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= accept && (cmd_op == OP_READ);
      if (accept && (cmd_op == OP_READ)) rd_data_o <= res_w;
    end
  end

  p_read_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_i && cmd_ready_o && (cmd_op_i == 4'd0)));
  p_mul_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_start |=> !cmd_ready_o);
  p_done_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_done_o |-> cmd_ready_o);
endmodule

// File: tb/test_cim_array_top.sv
module test_cim_array_top;
  localparam int ROWS  = 32;
  localparam int WIDTH = 32;
  localparam int AW    = $clog2(ROWS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [3:0]       cmd_op = '0;
  logic [AW-1:0]    cmd_ra = '0, cmd_rb = '0, cmd_rd = '0;
  logic [WIDTH-1:0] cmd_wdata = '0;
  logic             rd_valid, mul_done;
  logic [WIDTH-1:0] rd_data;

  logic [WIDTH-1:0] model [ROWS];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cim_array_top #(.ROWS(ROWS), .WIDTH(WIDTH)) i_cim_array_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_op_i    (cmd_op),
    .cmd_ra_i    (cmd_ra),
    .cmd_rb_i    (cmd_rb),
    .cmd_rd_i    (cmd_rd),
    .cmd_wdata_i (cmd_wdata),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .mul_done_o  (mul_done)
  );

  task automatic chk(input string req, input string what, input logic [WIDTH-1:0] act,
                     input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // issue one command; returns at the negedge after the accepting edge
  task automatic send(input logic [3:0] op, input int ra, input int rb, input int rd,
                      input logic [WIDTH-1:0] wd);
    logic [WIDTH-1:0] a, b, r;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_ra = AW'(ra); cmd_rb = AW'(rb); cmd_rd = AW'(rd); cmd_wdata = wd;
    cmd_valid = 1'b1;
    a = model[ra]; b = model[rb];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    r = '0;
    case (op)
      4'd1:  r = wd;
      4'd2:  r = a & b;
      4'd3:  r = ~(a | b);
      4'd4:  r = a | b;
      4'd5:  r = ~(a & b);
      4'd6:  r = a ^ b;
      4'd7:  r = ~(a ^ b);
      4'd8:  r = a + b;
      4'd9:  r = a << 1;
      4'd10: r = a >> 1;
      default: ;
    endcase
    if (op >= 4'd1 && op <= 4'd10) model[rd] = r;
  endtask

  task automatic read_chk(input string req, input int row);
    send(4'd0, row, row, 0, '0);
    chk(req, "rd_valid", WIDTH'(rd_valid), 1);
    chk(req, $sformatf("row %0d", row), rd_data, model[row]);
  endtask

  task automatic t_reset;
    chk("R1", "ready", WIDTH'(cmd_ready), 1);
    chk("R1", "rd_valid", WIDTH'(rd_valid), 0);
    chk("R1", "done", WIDTH'(mul_done), 0);
    read_chk("R1", 0);
    read_chk("R1", 31);
    @(posedge clk); @(negedge clk);
    chk("R2", "rd_valid one cycle", WIDTH'(rd_valid), 0);
  endtask

  task automatic t_write_read;
    send(4'd1, 0, 0, 1, 32'hA5A5_0F0F);
    send(4'd1, 0, 0, 2, 32'h0FF0_33CC);
    send(4'd1, 0, 0, 3, 32'hFFFF_FFFF);
    send(4'd1, 0, 0, 4, 32'h0000_0001);
    read_chk("R2", 1);
    read_chk("R2", 2);
    read_chk("R2", 3);
  endtask

  task automatic t_logic;
    send(4'd2, 1, 2, 10, '0); read_chk("R3 and", 10);
    send(4'd3, 1, 2, 11, '0); read_chk("R3 nor", 11);
    send(4'd4, 1, 2, 12, '0); read_chk("R4 or", 12);
    send(4'd5, 1, 2, 13, '0); read_chk("R4 nand", 13);
    send(4'd6, 1, 2, 14, '0); read_chk("R4 xor", 14);
    send(4'd7, 1, 2, 15, '0); read_chk("R4 xnor", 15);
    chk("R4", "xor value", model[14], 32'hAA55_3CC3);
  endtask

  task automatic t_add;
    send(4'd8, 3, 4, 16, '0); read_chk("R5 wrap", 16);
    chk("R5", "all ones plus one", model[16], 32'h0);
    send(4'd8, 1, 2, 17, '0); read_chk("R5 sum", 17);
    send(4'd1, 0, 0, 18, 32'h7FFF_FFFF);
    send(4'd8, 18, 18, 18, '0); read_chk("R10 in place add", 18);
    chk("R10", "doubled", model[18], 32'hFFFF_FFFE);
  endtask

  task automatic t_shift;
    send(4'd1, 0, 0, 19, 32'h8000_0001);
    send(4'd9, 19, 3, 20, '0); read_chk("R6 shl", 20);
    chk("R6", "shl value", model[20], 32'h0000_0002);
    send(4'd10, 19, 3, 21, '0); read_chk("R6 shr", 21);
    chk("R6", "shr value", model[21], 32'h4000_0000);
    send(4'd10, 19, 19, 19, '0); read_chk("R10 in place shr", 19);
  endtask

  task automatic t_mul(input int ra, input int rb, input int rd, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input bit probe);
    int n;
    logic [WIDTH-1:0] prod;
    send(4'd1, 0, 0, ra, a);
    send(4'd1, 0, 0, rb, b);
    prod = model[ra] * model[rb];
    send(4'd11, ra, rb, rd, '0);
    chk("R8", "ready low after accept", WIDTH'(cmd_ready), 0);
    n = 0;
    if (probe) begin
      // write held across an edge while busy must be dropped
      cmd_op = 4'd1; cmd_rd = AW'(5); cmd_wdata = 32'hDEAD_BEEF; cmd_valid = 1'b1;
      @(posedge clk); n++;
      @(negedge clk); cmd_valid = 1'b0;
    end
    while (n < 500) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (mul_done) break;
    end
    chk("R8", "done latency", WIDTH'(n), WIDTH'(2 * WIDTH + 4));
    chk("R8", "ready at done", WIDTH'(cmd_ready), 1);
    @(posedge clk); @(negedge clk);
    chk("R8", "done single pulse", WIDTH'(mul_done), 0);
    model[ROWS-1] = prod;
    model[ROWS-2] = '0;
    model[rd] = prod;
    read_chk("R7 product", rd);
    read_chk("R7 scratch acc", ROWS - 1);
    read_chk("R7 scratch mcd", ROWS - 2);
    if (probe) read_chk("R9 busy write dropped", 5);
  endtask

  task automatic t_illegal;
    send(4'd1, 0, 0, 6, 32'h1234_5678);
    send(4'd12, 1, 2, 6, 32'hFFFF_0000);
    send(4'd15, 3, 3, 6, 32'h0);
    read_chk("R9 reserved opcode", 6);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_logic();
    t_add();
    t_shift();
    t_mul(7, 8, 9, 32'd3, 32'd5, 1'b1);
    chk("R7", "3x5", model[9], 32'd15);
    t_mul(7, 8, 9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk("R7", "ones squared", model[9], 32'd1);
    t_mul(31, 30, 30, 32'd7, 32'd9, 1'b0);
    chk("R7", "scratch operands", model[30], 32'd63);
    t_illegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule